// File: doc/BRIEF.md
# Program/Erase Status Read Logic

This block forms the byte a host sees when it reads a non-volatile memory while an internal program or erase is in progress. The host detects completion by polling. While an operation runs, the top bit of the returned byte is the inverse of the corresponding bit of the byte being written; for an erase it reads 0. The next bit changes value on every fresh read. All other bits read 0. Once the internal timer signals the end of the operation, reads return the array contents again.

The array, the command decoder and the operation timer are outside the block. The decoder gives a one-cycle start pulse with the operation kind and the polled data bit. The timer gives a one-cycle done pulse. The array supplies read data. The bus strobes are active low and are sampled on the block clock. The output byte and its tri-state enable are registered, so they follow the bus one cycle later.

Top module: `flash_status_read`

## Requirements
- R1: One cycle after chip enable low, output enable low, write enable high and bus reset high are all present together, `dout_oe` is 1.
- R2: One cycle after chip enable high, output enable high, write enable low or bus reset low, `dout_oe` is 0 and `dout` is all zeros.
- R3: With no operation running, a read returns, one cycle later, the `arr_rdata` value presented in the read cycle.
- R4: While a program runs, bit 7 of a read returns the inverse of the `op_poll_bit` captured with the start pulse.
- R5: While an erase runs (`op_erase`=1 at start), bit 7 of a read returns 0.
- R6: While an operation runs, bit 6 changes value on the first cycle of each new read (strobe onset) and holds steady for the rest of a continuous read.
- R7: A start pulse sets the toggle to 0 without flipping it, even when a read onset falls in the same cycle. The first fresh read afterwards therefore shows bit 6 = 1.
- R8: While an operation runs, bits 5 down to 0 of a read are 0.
- R9: From the cycle of the done pulse on, reads return true array data, including a read whose onset coincides with the done pulse. A start pulse in the same cycle as a done pulse wins.
- R10: Synchronous reset (`rst_n` low) drives `dout_oe` and `dout` to 0 and ends any running operation, so the first read after reset returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_n | input | 1 | Bus reset strobe, low forces high impedance |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| arr_rdata | input | DW | Array read data for the current address |
| op_start | input | 1 | One-cycle pulse: an operation begins |
| op_erase | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| op_poll_bit | input | 1 | Bit 7 of the byte being programmed, taken with `op_start` |
| op_done | input | 1 | One-cycle pulse from the timer: the operation finished |
| dout | output | DW | Data byte to the bus driver |
| dout_oe | output | 1 | Tri-state enable for `dout` |

## Verification
Two functions can meet in one cycle: the onset of a read can land on the start pulse or on the done pulse. In the first case the toggle reset and the toggle advance compete. In the second case the end of status reporting and the status read compete. The bench drives both pairings on purpose, and also a done pulse in the middle of a continuous read. It judges each cycle against a next-state model built from R6, R7 and R9, in which the start pulse wins over the toggle and the done pulse makes the same-cycle read return array data.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
// Shared types for the status read logic.
package fsr_pkg;
    // Kind of embedded operation in progress.
    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;
endpackage

// File: rtl/fsr_read_detect.sv
`timescale 1ns/1ps
// Read strobe detector.
// Combines the bus strobes into a read-active level and flags the first
// clock of each read (onset). Assumes the strobes are already synchronous.
module fsr_read_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic bus_rst_n,
    output logic rd_act,
    output logic rd_onset
);
    logic rd_q;

    // Read is active when selected, output enabled, not writing, not in bus reset.
    always_comb rd_act = !ce_n && !oe_n && we_n && bus_rst_n;

    // Remember last cycle's read level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_act;
    end

    assign rd_onset = rd_act && !rd_q;

    // R6: an onset cannot repeat in the very next cycle.
    assert_onset_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_onset |=> !rd_onset);
endmodule

// File: rtl/fsr_op_track.sv
`timescale 1ns/1ps
// Operation tracker.
// Holds the busy flag, the operation kind, the polled data bit and the
// toggle flip-flop. Publishes next-state values so that a read in the same
// cycle as a start or done pulse sees the state after that pulse.
// Assumes op_start and op_done are single-cycle pulses.
module fsr_op_track
    import fsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_start,
    input  logic     op_erase,
    input  logic     op_poll_bit,
    input  logic     op_done,
    input  logic     rd_onset,
    output logic     busy_q,
    output logic     busy_nx,
    output op_kind_e kind_nx,
    output logic     poll_nx,
    output logic     tog_nx
);
    op_kind_e kind_q;
    logic     poll_q;
    logic     tog_q;

    // Next-state: start wins over done; the toggle advances on read onset while busy.
    always_comb begin
        busy_nx = op_start || (busy_q && !op_done);
        kind_nx = op_start ? op_kind_e'(op_erase) : kind_q;
        poll_nx = op_start ? op_poll_bit : poll_q;
        if (op_start)                tog_nx = 1'b0;
        else if (busy_q && rd_onset) tog_nx = !tog_q;
        else                         tog_nx = tog_q;
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= OP_PROGRAM;
            poll_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            busy_q <= busy_nx;
            kind_q <= kind_nx;
            poll_q <= poll_nx;
            tog_q  <= tog_nx;
        end
    end

    // R7: a start leaves the block busy with the toggle cleared.
    assert_start_clears_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (busy_q && !tog_q));
    // R6: each read onset during busy flips the toggle.
    assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rd_onset && !op_start) |=> (tog_q != $past(tog_q)));
    // R6: without onset or start the toggle holds.
    assert_toggle_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_onset && !op_start) |=> $stable(tog_q));
    // R9: done without start ends busy.
    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_start) |=> !busy_q);
endmodule

// File: rtl/fsr_status_mux.sv
`timescale 1ns/1ps
// Status byte multiplexer.
// Builds the status byte bit by bit and selects between it, array data and
// zero. Assumes POLL_BIT and TOG_BIT are distinct positions below DW.
module fsr_status_mux
    import fsr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          rd_act,
    input  logic          busy,
    input  op_kind_e      kind,
    input  logic          poll,
    input  logic          tog,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] dout_d
);
    logic [DW-1:0] stat;

    // One status bit per lane: polled bit, toggle bit, or zero fill.
    for (genvar g = 0; g < DW; g++) begin : g_lane
        if (g == POLL_BIT) begin : g_poll
            assign stat[g] = (kind == OP_ERASE) ? 1'b0 : !poll;
        end else if (g == TOG_BIT) begin : g_tog
            assign stat[g] = tog;
        end else begin : g_fill
            assign stat[g] = 1'b0;
        end
    end

    // Pick zero when not reading, status while busy, otherwise array data.
    always_comb begin
        if (!rd_act)   dout_d = '0;
        else if (busy) dout_d = stat;
        else           dout_d = arr_rdata;
    end
endmodule

// File: rtl/flash_status_read.sv
`timescale 1ns/1ps
// Program/erase status read logic, top level.
// Registers the selected byte and its tri-state enable one cycle after the
// bus strobes. Assumes all inputs are synchronous to clk.
module flash_status_read
    import fsr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [DW-1:0] arr_rdata,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic          op_poll_bit,
    input  logic          op_done,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    logic          rd_act, rd_onset;
    logic          busy_q, busy_nx, poll_nx, tog_nx;
    op_kind_e      kind_nx;
    logic [DW-1:0] dout_d, dout_q;
    logic          oe_q;

    fsr_read_detect u_detect (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .bus_rst_n(bus_rst_n), .rd_act(rd_act), .rd_onset(rd_onset)
    );

    fsr_op_track u_track (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
        .op_poll_bit(op_poll_bit), .op_done(op_done), .rd_onset(rd_onset),
        .busy_q(busy_q), .busy_nx(busy_nx), .kind_nx(kind_nx),
        .poll_nx(poll_nx), .tog_nx(tog_nx)
    );

    fsr_status_mux #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_mux (
        .rd_act(rd_act), .busy(busy_nx), .kind(kind_nx), .poll(poll_nx),
        .tog(tog_nx), .arr_rdata(arr_rdata), .dout_d(dout_d)
    );

    // Output stage: register data and enable for the bus driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            dout_q <= dout_d;
            oe_q   <= rd_act;
        end
    end

    assign dout    = dout_q;
    assign dout_oe = oe_q;

    // R1: a full read strobe enables the outputs next cycle.
    assert_drive_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && bus_rst_n) |=> dout_oe);
    // R2: any gating condition gives high impedance and zero data.
    assert_hiz_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n || !bus_rst_n) |=> (!dout_oe && dout == '0));
    // R3: idle read passes array data through.
    assert_idle_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !busy_q && !op_start) |=> (dout == $past(arr_rdata)));
    // R5: erase started with a read in the same cycle reports polled bit 0.
    assert_erase_poll_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && op_start && op_erase) |=> !dout[POLL_BIT]);
    // R9: read coinciding with done returns array data.
    assert_done_true_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && op_done && !op_start) |=> (dout == $past(arr_rdata)));
endmodule

// File: tb/flash_status_read_bench.sv
`timescale 1ns/1ps
module flash_status_read_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, bus_rst_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0] arr_rdata = 8'h00;
    logic       op_start = 1'b0, op_erase = 1'b0, op_poll_bit = 1'b0, op_done = 1'b0;
    logic [7:0] dout;
    logic       dout_oe;

    int n_chk = 0, n_err = 0;
    bit fin = 0;
    // reference model state
    logic m_busy = 0, m_tog = 0, m_rdq = 0, m_kind = 0, m_pb = 0;

    always #2.5 clk = ~clk;

    flash_status_read u_flash_status_read (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .arr_rdata(arr_rdata), .op_start(op_start), .op_erase(op_erase),
        .op_poll_bit(op_poll_bit), .op_done(op_done), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, wait to the next falling edge, compare to model.
    task automatic step(input logic rn, input logic c, input logic o, input logic w,
                        input logic b, input logic st, input logic er, input logic pb,
                        input logic dn, input logic [7:0] ar);
        logic rd, onset, bn, tn, kn, pn;
        logic [7:0] exp_d;
        rst_n = rn; ce_n = c; oe_n = o; we_n = w; bus_rst_n = b;
        op_start = st; op_erase = er; op_poll_bit = pb; op_done = dn; arr_rdata = ar;
        @(negedge clk);
        rd = !c && !o && w && b;
        if (!rn) begin
            m_busy = 0; m_tog = 0; m_rdq = 0; m_kind = 0; m_pb = 0;
            chk({7'b0, dout_oe}, 8'h00, "R10 reset enable");
            chk(dout, 8'h00, "R10 reset data");
        end else begin
            onset = rd && !m_rdq;
            bn = st || (m_busy && !dn);
            tn = st ? 1'b0 : ((m_busy && onset) ? !m_tog : m_tog);
            kn = st ? er : m_kind;
            pn = st ? pb : m_pb;
            chk({7'b0, dout_oe}, {7'b0, rd}, rd ? "R1 enable" : "R2 enable");
            if (!rd) begin
                chk(dout, 8'h00, "R2 data");
            end else if (bn) begin
                chk({7'b0, dout[7]}, {7'b0, kn ? 1'b0 : !pn}, kn ? "R5 erase poll" : "R4 program poll");
                chk({7'b0, dout[6]}, {7'b0, tn}, st ? "R7 toggle at start" : "R6 toggle");
                chk({2'b0, dout[5:0]}, 8'h00, "R8 fill");
            end else begin
                exp_d = ar;
                chk(dout, exp_d, (dn || m_busy) ? "R9 done data" : "R3 idle data");
            end
            m_busy = bn; m_tog = tn; m_kind = kn; m_pb = pn; m_rdq = rd;
        end
    endtask

    task automatic idle(input logic [7:0] ar);
        step(1, 1, 1, 1, 1, 0, 0, 0, 0, ar);
    endtask
    task automatic rdc(input logic [7:0] ar);
        step(1, 0, 0, 1, 1, 0, 0, 0, 0, ar);
    endtask

    initial begin
        // reset while a read strobe is applied
        step(0, 0, 0, 1, 1, 0, 0, 0, 0, 8'h5A);
        step(0, 0, 0, 1, 1, 0, 0, 0, 0, 8'hA5);
        idle(8'h00);

        // gating sweep over every strobe combination, idle and busy
        for (int busy = 0; busy < 2; busy++) begin
            if (busy == 1) step(1, 1, 1, 1, 1, 1, 0, 1, 0, 8'h00);
            for (int i = 0; i < 16; i++) begin
                step(1, i[0], i[1], i[2], i[3], 0, 0, 0, 0, 8'(i * 17 + 3));
                idle(8'(i));
            end
            if (busy == 1) step(1, 1, 1, 1, 1, 0, 0, 0, 1, 8'h00);
        end

        // operation sweep: program and erase with varied data and reads
        for (int k = 0; k < 256; k++) begin
            logic [7:0] a;
            a = 8'(k * 73 + 11);
            step(1, 1, 1, 1, 1, 1, (k % 3) == 0, a[7] ^ k[0], 0, a);
            for (int r = 0; r < 3; r++) begin
                rdc(a ^ 8'(r));
                idle(a);
            end
            rdc(a); rdc(~a);                      // R6 continuous read holds toggle
            idle(a);
            step(1, 1, 1, 1, 1, 0, 0, 0, 1, a);   // done
            rdc(a + 8'd1);                        // R9 true data after done
            idle(a);
        end

        // corner: start coincides with read onset (R7), then onset with done (R9)
        step(1, 0, 0, 1, 1, 1, 0, 0, 0, 8'h33);
        idle(8'h33);
        rdc(8'h44); idle(8'h44);
        step(1, 0, 0, 1, 1, 0, 0, 0, 1, 8'hC3);
        idle(8'h00);

        // corner: done in the middle of a continuous read
        step(1, 1, 1, 1, 1, 1, 1, 0, 0, 8'h00);
        rdc(8'h11); rdc(8'h12);
        step(1, 0, 0, 1, 1, 0, 0, 0, 1, 8'h99);
        rdc(8'h9A); idle(8'h00);

        // corner: start and done together, start wins (R9)
        step(1, 1, 1, 1, 1, 1, 0, 1, 0, 8'h00);
        step(1, 0, 0, 1, 1, 1, 0, 1, 1, 8'h77);
        rdc(8'h78); idle(8'h00);

        // corner: bus reset drops mid read while busy, onset again flips toggle
        rdc(8'h01);
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, 8'h02);
        rdc(8'h03);
        step(1, 0, 0, 0, 1, 0, 0, 0, 0, 8'h04);  // write enable low: not a read
        rdc(8'h05);

        // R10: block reset during an operation, first read returns array data
        step(0, 1, 1, 1, 1, 0, 0, 0, 0, 8'h00);
        rdc(8'hE7);
        chk(dout, 8'hE7, "R10 data after reset");
        idle(8'h00);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule